// File: doc/BRIEF.md
# Two-Channel Sequential Bus Break Detector

This block observes every bus cycle through two comparators, channel A and channel B. Each comparator has its own reference address, don't-care mask and control word. The control word selects the access kind, the direction, which bus master is observed, and whether a resulting break is taken before or after the instruction executes. In independent mode either channel may raise a break on its own. In sequential mode a break is raised only when channel B matches in a bus cycle that comes strictly after a cycle in which channel A matched. There is one exception: when channel A is set up as a pre-execution instruction-fetch break, a cycle in which A and B both match is enough.

The block arbitrates the break it finds against an instruction-fetch exception and an operand exception that arrive with the same bus cycle. It presents the winner as registered one-cycle grants. Configuration is held in eight registers reached through a small register port. Every access on that port passes through a fixed-latency stage. A write therefore takes effect a fixed number of cycles after it is issued, and a read returns its data once every earlier write has been applied.

Top module: `bus_break_unit`

## Requirements
- R1: A channel matches a valid bus cycle when the address agrees with the reference address in every bit whose mask bit is 0 (a mask bit of 1 means don't care), when the access kind is accepted, and when the direction is accepted. The control word holds these fields. Bits [1:0] select the kind: 0 means the channel is disabled, 1 means instruction fetch, 2 means data, 3 means either. Bits [3:2] select the direction: 1 means read, 2 means write, 0 or 3 mean either.
- R2: Control bit 4 selects the observed master (0 means CPU, 1 means DMA). A channel matches only cycles of that master.
- R3: In independent mode (sequential-control register bit 0 = 0), a match on either channel raises brk_req for exactly the cycle after the matching bus cycle. brk_post is taken from control bit 5 of the matching channel (1 means post-execution). If both channels match, brk_post is 1 only when both are post-execution.
- R4: In sequential mode, brk_req is raised only when channel B matches in a bus cycle after one in which channel A matched. A cycle in which A and B match together, with A not armed beforehand, raises no break and only arms A. A sequential break carries channel B's qualifier.
- R5: In sequential mode, when channel A is set for a pre-execution instruction-fetch break (kind 1, bit 5 = 0), a cycle in which A and B match together raises brk_req with brk_post = 0 and sets both match flags.
- R6: The armed state is cleared by reset, by a sequential break, and by any applied write to the sequential-control register.
- R7: The match flags register (address 7) holds channel A in bit 0 and channel B in bit 1. A flag is set by its channel's match in independent mode; both flags are set by a sequential break. A flag stays set until a write to address 7 places 0 in its bit; writing 1 leaves the flag unchanged.
- R8: For the same bus cycle, a fetch exception beats any break. A pre-execution break beats an operand exception. An operand exception beats a post-execution break. At most one of brk_req, take_fetch and take_oper is high in any cycle.
- R9: Register writes issued with reg_dma = 1 are ignored. Register reads issued with reg_dma = 1 return zero.
- R10: A write is applied LAT cycles after it is issued (LAT = 2 by default). A bus cycle presented in the cycle right after the write still compares against the old value. A read issued after a write returns reg_rvalid LAT cycles later with the new value, and that value is in force from then on.
- R11: After reset no outputs are active and every register reads zero.
- R12: Register addresses: 0 and 3 hold the reference addresses of A and B; 1 and 4 hold their masks; 2 and 5 hold their control words; 6 is the sequential control register; 7 holds the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_dma | input | 1 | Register access is issued by the DMA master |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| bus_valid | input | 1 | A bus cycle is presented |
| bus_addr | input | AW | Bus cycle address |
| bus_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_write | input | 1 | 1 for a write |
| bus_dma | input | 1 | 1 when the DMA master owns the cycle |
| exc_fetch | input | 1 | Fetch exception for this cycle |
| exc_oper | input | 1 | Operand exception for this cycle |
| brk_req | output | 1 | Break request pulse |
| brk_post | output | 1 | Qualifier: break after execution |
| take_fetch | output | 1 | Fetch exception granted |
| take_oper | output | 1 | Operand exception granted |

## Verification
A wrong armed state shows up one cycle after the next channel B match: a break is missing or appears where none should be. The sequences therefore arm, disarm and re-arm A, and in every case probe with a B-only cycle. A wrong flag or a wrong applied register value stays hidden until a read returns, LAT cycles after the read is issued. Every configuration step is therefore followed by a readback or by a probe bus cycle. Arbitration errors show in the cycle right after the bus cycle, as two grants at once or as the wrong grant.

// File: rtl/bbk_pkg.sv
package bbk_pkg;

  typedef enum logic [1:0] {
    KIND_OFF   = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_DATA  = 2'd2,
    KIND_ANY   = 2'd3
  } kind_sel_e;

  typedef enum logic [1:0] {
    DIR_EITHER0 = 2'd0,
    DIR_READ    = 2'd1,
    DIR_WRITE   = 2'd2,
    DIR_EITHER  = 2'd3
  } dir_sel_e;

  // [5] post, [4] dma master, [3:2] direction, [1:0] kind
  typedef struct packed {
    logic      post;
    logic      dma;
    dir_sel_e  dir;
    kind_sel_e kind;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  localparam logic [2:0] RA_REF_A  = 3'd0;
  localparam logic [2:0] RA_MSK_A  = 3'd1;
  localparam logic [2:0] RA_CTL_A  = 3'd2;
  localparam logic [2:0] RA_REF_B  = 3'd3;
  localparam logic [2:0] RA_MSK_B  = 3'd4;
  localparam logic [2:0] RA_CTL_B  = 3'd5;
  localparam logic [2:0] RA_SEQ    = 3'd6;
  localparam logic [2:0] RA_FLAGS  = 3'd7;

  function automatic logic kind_ok(input kind_sel_e k, input logic is_fetch);
    case (k)
      KIND_FETCH: return is_fetch;
      KIND_DATA:  return !is_fetch;
      KIND_ANY:   return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic dir_ok(input dir_sel_e d, input logic is_write);
    case (d)
      DIR_READ:  return !is_write;
      DIR_WRITE: return is_write;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/bbk_channel.sv
module bbk_channel
  import bbk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] dc_mask,
  input  chan_ctrl_t    ctrl,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic          bus_dma,
  output logic          hit
);

  function automatic logic addr_hit(input logic [AW-1:0] a,
                                    input logic [AW-1:0] r,
                                    input logic [AW-1:0] m);
    return ((a ^ r) & ~m) == '0;
  endfunction

  logic master_ok;
  assign master_ok = (bus_dma == ctrl.dma);

  assign hit = bus_valid && master_ok
            && kind_ok(ctrl.kind, bus_fetch)
            && dir_ok(ctrl.dir, bus_write)
            && addr_hit(bus_addr, ref_addr, dc_mask);

endmodule

// File: rtl/bbk_regfile.sv
module bbk_regfile
  import bbk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_dma,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  input  logic [1:0]    flags_in,
  output logic [AW-1:0] ref_a,
  output logic [AW-1:0] msk_a,
  output chan_ctrl_t    ctl_a,
  output logic [AW-1:0] ref_b,
  output logic [AW-1:0] msk_b,
  output chan_ctrl_t    ctl_b,
  output logic          seq_en,
  output logic          seq_wr_commit,
  output logic [1:0]    flag_clr,
  output logic [AW-1:0] reg_rdata,
  output logic          reg_rvalid
);

  localparam int TAIL = LAT - 1;

  logic [LAT-1:0] p_wr, p_rd, p_dma;
  logic [2:0]     p_addr [LAT];
  logic [AW-1:0]  p_data [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_wr  <= '0;
      p_rd  <= '0;
      p_dma <= '0;
      for (int i = 0; i < LAT; i++) begin
        p_addr[i] <= '0;
        p_data[i] <= '0;
      end
    end else begin
      p_wr[0]   <= reg_wr && !reg_dma;
      p_rd[0]   <= reg_rd;
      p_dma[0]  <= reg_dma;
      p_addr[0] <= reg_addr;
      p_data[0] <= reg_wdata;
      for (int i = 1; i < LAT; i++) begin
        p_wr[i]   <= p_wr[i-1];
        p_rd[i]   <= p_rd[i-1];
        p_dma[i]  <= p_dma[i-1];
        p_addr[i] <= p_addr[i-1];
        p_data[i] <= p_data[i-1];
      end
    end
  end

  logic          commit_wr;
  logic [2:0]    commit_addr;
  logic [AW-1:0] commit_data;
  assign commit_wr   = p_wr[TAIL];
  assign commit_addr = p_addr[TAIL];
  assign commit_data = p_data[TAIL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a  <= '0;
      msk_a  <= '0;
      ctl_a  <= '0;
      ref_b  <= '0;
      msk_b  <= '0;
      ctl_b  <= '0;
      seq_en <= 1'b0;
    end else if (commit_wr) begin
      case (commit_addr)
        RA_REF_A: ref_a  <= commit_data;
        RA_MSK_A: msk_a  <= commit_data;
        RA_CTL_A: ctl_a  <= chan_ctrl_t'(commit_data[CTRL_W-1:0]);
        RA_REF_B: ref_b  <= commit_data;
        RA_MSK_B: msk_b  <= commit_data;
        RA_CTL_B: ctl_b  <= chan_ctrl_t'(commit_data[CTRL_W-1:0]);
        RA_SEQ:   seq_en <= commit_data[0];
        default:  ;
      endcase
    end
  end

  assign seq_wr_commit = commit_wr && (commit_addr == RA_SEQ);
  assign flag_clr      = (commit_wr && (commit_addr == RA_FLAGS)) ? ~commit_data[1:0] : 2'b00;

  logic [AW-1:0] rd_mux;
  always_comb begin
    case (commit_addr)
      RA_REF_A: rd_mux = ref_a;
      RA_MSK_A: rd_mux = msk_a;
      RA_CTL_A: rd_mux = {{(AW-CTRL_W){1'b0}}, ctl_a};
      RA_REF_B: rd_mux = ref_b;
      RA_MSK_B: rd_mux = msk_b;
      RA_CTL_B: rd_mux = {{(AW-CTRL_W){1'b0}}, ctl_b};
      RA_SEQ:   rd_mux = {{(AW-1){1'b0}}, seq_en};
      default:  rd_mux = {{(AW-2){1'b0}}, flags_in};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= p_rd[TAIL];
      if (p_rd[TAIL]) reg_rdata <= p_dma[TAIL] ? '0 : rd_mux;
    end
  end

  // R10
  cfg_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_a) |-> $past(commit_wr));

  // R9
  dma_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid && $past(p_dma[TAIL])) |-> (reg_rdata == '0));

endmodule

// File: rtl/bbk_match_seq.sv
module bbk_match_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_en,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       a_pre_fetch,
  input  logic       a_post,
  input  logic       b_post,
  input  logic       seq_wr_commit,
  input  logic [1:0] flag_clr,
  output logic       cond,
  output logic       cond_post,
  output logic [1:0] flags,
  output logic       armed
);

  logic same_cycle_ok;
  logic seq_cond;
  logic [1:0] flag_set;

  assign same_cycle_ok = a_pre_fetch && hit_a && hit_b;
  assign seq_cond      = seq_en && ((armed && hit_b) || same_cycle_ok);

  always_comb begin
    if (seq_en) begin
      cond      = seq_cond;
      cond_post = same_cycle_ok ? 1'b0 : b_post;
      flag_set  = {seq_cond, seq_cond};
    end else begin
      cond      = hit_a || hit_b;
      cond_post = (!hit_a || a_post) && (!hit_b || b_post);
      flag_set  = {hit_b, hit_a};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      flags <= 2'b00;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (seq_wr_commit || seq_cond || !seq_en) armed <= 1'b0;
      else if (hit_a)                           armed <= 1'b1;
    end
  end

  // R4
  seq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && hit_b && !armed && !same_cycle_ok) |-> !cond);

  // R6
  disarm_after_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && cond) |=> !armed);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(flag_clr[0]));

endmodule

// File: rtl/bbk_arbiter.sv
module bbk_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic cond_post,
  input  logic exc_fetch,
  input  logic exc_oper,
  output logic brk_req,
  output logic brk_post,
  output logic take_fetch,
  output logic take_oper
);

  logic brk_win, oper_win;
  assign brk_win  = cond && !exc_fetch && !(cond_post && exc_oper);
  assign oper_win = exc_oper && !exc_fetch && !(cond && !cond_post);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req    <= 1'b0;
      brk_post   <= 1'b0;
      take_fetch <= 1'b0;
      take_oper  <= 1'b0;
    end else begin
      brk_req    <= brk_win;
      brk_post   <= brk_win && cond_post;
      take_fetch <= exc_fetch;
      take_oper  <= oper_win;
    end
  end

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({brk_req, take_fetch, take_oper}) <= 1);

  // R8
  pre_beats_oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && !cond_post && exc_oper && !exc_fetch) |=> (brk_req && !brk_post));

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_dma,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          reg_rvalid,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic          bus_dma,
  input  logic          exc_fetch,
  input  logic          exc_oper,
  output logic          brk_req,
  output logic          brk_post,
  output logic          take_fetch,
  output logic          take_oper
);

  localparam int NCH = 2;

  logic [AW-1:0] ref_r [NCH];
  logic [AW-1:0] msk_r [NCH];
  chan_ctrl_t    ctl_r [NCH];
  logic [NCH-1:0] hit;
  logic          seq_en, seq_wr_commit;
  logic [1:0]    flag_clr, flags;
  logic          cond, cond_post, armed;

  bbk_regfile #(.AW(AW), .LAT(LAT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_dma(reg_dma),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flags_in(flags),
    .ref_a(ref_r[0]), .msk_a(msk_r[0]), .ctl_a(ctl_r[0]),
    .ref_b(ref_r[1]), .msk_b(msk_r[1]), .ctl_b(ctl_r[1]),
    .seq_en(seq_en), .seq_wr_commit(seq_wr_commit), .flag_clr(flag_clr),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bbk_channel #(.AW(AW)) u_chan (
      .ref_addr(ref_r[c]), .dc_mask(msk_r[c]), .ctrl(ctl_r[c]),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_fetch(bus_fetch),
      .bus_write(bus_write), .bus_dma(bus_dma), .hit(hit[c])
    );
  end

  logic a_pre_fetch;
  assign a_pre_fetch = (ctl_r[0].kind == KIND_FETCH) && !ctl_r[0].post;

  bbk_match_seq u_seq (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en),
    .hit_a(hit[0]), .hit_b(hit[1]), .a_pre_fetch(a_pre_fetch),
    .a_post(ctl_r[0].post), .b_post(ctl_r[1].post),
    .seq_wr_commit(seq_wr_commit), .flag_clr(flag_clr),
    .cond(cond), .cond_post(cond_post), .flags(flags), .armed(armed)
  );

  bbk_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .cond(cond), .cond_post(cond_post),
    .exc_fetch(exc_fetch), .exc_oper(exc_oper),
    .brk_req(brk_req), .brk_post(brk_post),
    .take_fetch(take_fetch), .take_oper(take_oper)
  );

  // R2
  master_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_dma != ctl_r[0].dma) && (bus_dma != ctl_r[1].dma) && !exc_fetch && !exc_oper)
      |=> !brk_req);

endmodule

// File: tb/bus_break_unit_test.sv
module bus_break_unit_test;

  localparam int AW  = 32;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, reg_dma = 0;
  logic [2:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic reg_rvalid;
  logic bus_valid = 0, bus_fetch = 0, bus_write = 0, bus_dma = 0;
  logic [AW-1:0] bus_addr = '0;
  logic exc_fetch = 0, exc_oper = 0;
  logic brk_req, brk_post, take_fetch, take_oper;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bus_break_unit #(.AW(AW), .LAT(LAT)) uut (.*);

  typedef struct packed {
    logic [31:0] a;
    logic f, w, d, eb, ep;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h1004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h1010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h100C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1004, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h2000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h200F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_now(input logic [2:0] a, input logic [31:0] d, input logic dma);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_dma = dma;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; reg_dma = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_now(a, d, 1'b0);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic dma, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; reg_dma = dma;
    @(posedge clk); @(negedge clk);
    reg_rd = 0; reg_dma = 0;
    for (int k = 0; k < 10 && !reg_rvalid; k++) @(negedge clk);
    d = reg_rvalid ? reg_rdata : 32'hDEAD_BEEF;
    @(negedge clk);
  endtask

  // one bus cycle; outputs are registered, checked at the following negedge
  task automatic bus(input logic [31:0] a, input logic f, input logic w, input logic d,
                     input logic xf, input logic xo);
    bus_valid = 1; bus_addr = a; bus_fetch = f; bus_write = w; bus_dma = d;
    exc_fetch = xf; exc_oper = xo;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; exc_fetch = 0; exc_oper = 0; bus_dma = 0;
  endtask

  task automatic expect_brk(input string req, input logic eb, input logic ep);
    check(req, {31'b0, brk_req}, {31'b0, eb});
    if (eb) check(req, {31'b0, brk_post}, {31'b0, ep});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check("R11 brk", {28'b0, brk_req, brk_post, take_fetch, take_oper}, 32'h0);
    rd(3'd7, 1'b0, d); check("R11 flags", d, 32'h0);
    rd(3'd0, 1'b0, d); check("R11 ref_a", d, 32'h0);

    // configure: A fetch, any dir, CPU, pre; B data write, CPU, post
    wr(3'd0, 32'h1000); wr(3'd1, 32'hF); wr(3'd2, 32'h0D);
    wr(3'd3, 32'h2000); wr(3'd4, 32'h0); wr(3'd5, 32'h2A);
    rd(3'd2, 1'b0, d); check("R12 ctl_a", d, 32'h0D);

    // R1 R2 R3 vector table
    foreach (VECS[i]) begin
      bus(VECS[i].a, VECS[i].f, VECS[i].w, VECS[i].d, 1'b0, 1'b0);
      expect_brk($sformatf("R1 R3 vec%0d", i), VECS[i].eb, VECS[i].ep);
      @(negedge clk);
      check("R3 pulse", {31'b0, brk_req}, 32'h0);
    end

    // R7 flags sticky and cleared by writing zero
    rd(3'd7, 1'b0, d); check("R7 flags set", d, 32'h3);
    wr(3'd7, 32'h2); rd(3'd7, 1'b0, d); check("R7 clear A", d, 32'h2);
    wr(3'd7, 32'h0); rd(3'd7, 1'b0, d); check("R7 clear B", d, 32'h0);

    // R9 DMA register access
    wr_now(3'd0, 32'hFFFF, 1'b1); repeat (LAT + 1) @(negedge clk);
    rd(3'd0, 1'b0, d); check("R9 dma write ignored", d, 32'h1000);
    rd(3'd0, 1'b1, d); check("R9 dma read zero", d, 32'h0);

    // R2 channel B observes DMA only
    wr(3'd5, 32'h3A);
    bus(32'h2000, 0, 1, 1, 0, 0); expect_brk("R2 dma seen", 1, 1);
    bus(32'h2000, 0, 1, 0, 0, 0); expect_brk("R2 cpu ignored", 0, 0);
    wr(3'd5, 32'h2A);

    // R10 write latency
    wr_now(3'd0, 32'h3000, 1'b0);
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R10 old value", 1, 0);
    rd(3'd0, 1'b0, d); check("R10 readback", d, 32'h3000);
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R10 old gone", 0, 0);
    bus(32'h3004, 1, 0, 0, 0, 0); expect_brk("R10 new value", 1, 0);
    wr(3'd0, 32'h1000);

    // R8 priority
    bus(32'h1004, 1, 0, 0, 1, 0);
    expect_brk("R8 fetch exc beats", 0, 0);
    check("R8 take_fetch", {31'b0, take_fetch}, 32'h1);
    bus(32'h1004, 1, 0, 0, 0, 1);
    expect_brk("R8 pre beats oper", 1, 0);
    check("R8 oper lost", {31'b0, take_oper}, 32'h0);
    bus(32'h2000, 0, 1, 0, 0, 1);
    expect_brk("R8 oper beats post", 0, 0);
    check("R8 take_oper", {31'b0, take_oper}, 32'h1);
    bus(32'h2000, 0, 1, 0, 1, 1);
    check("R8 fetch over all", {29'b0, brk_req, take_fetch, take_oper}, 32'h2);

    // R4 sequential mode
    wr(3'd6, 32'h1); wr(3'd7, 32'h0);
    bus(32'h2000, 0, 1, 0, 0, 0); expect_brk("R4 B alone", 0, 0);
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R4 A arms", 0, 0);
    bus(32'h2000, 0, 1, 0, 0, 0); expect_brk("R4 A then B", 1, 1);
    bus(32'h2000, 0, 1, 0, 0, 0); expect_brk("R6 disarmed", 0, 0);

    // R6 write to sequential control disarms
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R6 arm", 0, 0);
    wr(3'd6, 32'h1);
    bus(32'h2000, 0, 1, 0, 0, 0); expect_brk("R6 seq write clears", 0, 0);

    // R5 same-cycle special case; B matches the same fetch
    wr(3'd3, 32'h1000); wr(3'd4, 32'hF); wr(3'd5, 32'h2F); wr(3'd7, 32'h0);
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R5 same cycle", 1, 0);
    rd(3'd7, 1'b0, d); check("R5 both flags", d, 32'h3);

    // R4 same cycle without special case only arms
    wr(3'd2, 32'h0F); wr(3'd7, 32'h0);
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R4 same cycle none", 0, 0);
    rd(3'd7, 1'b0, d); check("R4 no flags", d, 32'h0);
    bus(32'h1004, 1, 0, 0, 0, 0); expect_brk("R4 later B", 1, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule